// File: doc/BRIEF.md
# Serial Memory Page Write Controller

This block handles every write-type command of a 512-byte serial memory. A serial front-end turns the bit stream into one-cycle pulses for a decoded instruction, a received byte and the rise of chip select. It also reports whether that rise landed on a byte boundary. From these pulses the block runs the write-enable latch and collects up to one page of data in a 16-byte buffer. It then decides, at the moment chip select rises, whether the collected page is committed.

A committed page starts a timed internal write cycle. In the first cycles of that window, every buffered byte is sent once through a simple write port into the memory array. The write-in-progress flag stays high for the whole window. Status stays readable while the cycle runs, and commands that would change state are ignored. The block also holds the two block-protect bits. They are decoded here into a simplified protected address range, and writes into that range are refused.

Top module: `page_write_ctrl`

## Requirements
- R1: Command code 1 (enable) sets the enable latch (status bit 1) only if the next chip-select rise is byte aligned and no further byte arrived in that session. Otherwise the latch keeps its previous value.
- R2: Command code 2 (disable) clears the enable latch at once. While a write cycle runs, it is ignored.
- R3: Command code 3 (write) is accepted only when the enable latch is set, the write-permit input is high and no write cycle runs. The address bit A8 comes with the command. The next byte is the low address, and the bytes after it are data.
- R4: The first data byte goes to page index address[3:0]. Each later byte goes to the next index, and the index wraps from 15 to 0 inside the same page. A later byte at the same index replaces the earlier one.
- R5: A write commits only when chip select rises byte aligned after at least one data byte. Any other rise aborts the session. An aborted session writes nothing and leaves the enable latch unchanged.
- R6: A commit holds status bit 0 (WIP) high for exactly WR_CYCLES clock cycles. During that window, each buffered byte is written exactly once to address {page, index}.
- R7: The enable latch is cleared when a write cycle ends.
- R8: While a write cycle runs, enable, write and status-write commands have no effect, and the status output remains valid.
- R9: Command code 4 (status write) with the latch set copies bits 3:2 of the next byte into status bits 3:2 (BP1, BP0). Without the latch set, it does nothing.
- R10: Protection by {BP1,BP0} works as follows: 00 protects nothing, 01 protects addresses 0x180-0x1FF, 10 protects 0x100-0x1FF and 11 protects all addresses. A write to a protected page does not commit.
- R11: After reset the status is zero and no array write occurs. Status bits 7:4 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Pulse: an instruction byte was decoded |
| cmd_code | input | 3 | Decoded instruction (1 enable, 2 disable, 3 write, 4 status write, others no write action) |
| cmd_a8 | input | 1 | Address bit A8 carried in the write instruction |
| byte_valid | input | 1 | Pulse: a byte following the instruction was received |
| byte_data | input | 8 | Received byte |
| cs_rise | input | 1 | Pulse: chip select was deasserted |
| cs_aligned | input | 1 | With cs_rise: the deassertion fell on a byte boundary |
| wr_permit | input | 1 | Write-protect pin level; high allows writes |
| status | output | 8 | {4'b0, BP1, BP0, WEL, WIP} |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 9 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
A table of page-write sessions varies the start index, the number of data bytes (none, one, a full page, more than a page) and the chip-select alignment. It also varies whether the enable latch was set and the level of the write-permit pin. A full page that starts mid-page shows the index wrap, and twenty bytes show the overwrite of early bytes. The misaligned, empty, unlatched and write-protected rows are the aborts, and each must leave the array and the write counter untouched. Directed sessions then cover the latch rules, commands sent during a running cycle, and writes on both sides of each protected-range boundary.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
    localparam int ADDR_W     = 9;
    localparam int DATA_W     = 8;
    localparam int PAGE_BYTES = 16;
    localparam int IDX_W      = $clog2(PAGE_BYTES);
    localparam int PAGE_W     = ADDR_W - IDX_W;

    typedef enum logic [2:0] {
        OP_OTHER = 3'd0,
        OP_WREN  = 3'd1,
        OP_WRDI  = 3'd2,
        OP_WRITE = 3'd3,
        OP_WRSR  = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        SS_IDLE,
        SS_EN_WAIT,
        SS_ADDR,
        SS_DATA,
        SS_SR,
        SS_SKIP
    } sess_e;

    // Simplified protected range: 01 upper quarter, 10 upper half, 11 all.
    function automatic logic page_locked(input logic [PAGE_W-1:0] page,
                                         input logic [1:0] bp);
        logic r;
        case (bp)
            2'b00:   r = 1'b0;
            2'b01:   r = (page[PAGE_W-1:PAGE_W-2] == 2'b11);
            2'b10:   r = page[PAGE_W-1];
            default: r = 1'b1;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/pwc_page_buf.sv
module pwc_page_buf
    import pwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [IDX_W-1:0]  idx_init,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              has_data
);
    typedef struct packed {
        logic [PAGE_BYTES-1:0][DATA_W-1:0] mem;
        logic [PAGE_BYTES-1:0]             mask;
        logic [IDX_W-1:0]                  idx;
    } buf_t;

    buf_t q, d;

    always_comb begin
        d = q;
        if (clear) begin
            d.mask = '0;
            d.idx  = idx_init;
        end else if (wr) begin
            d.mem[q.idx]  = wdata;
            d.mask[q.idx] = 1'b1;
            d.idx         = q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data  = q.mem[rd_idx];
    assign rd_valid = q.mask[rd_idx];
    assign has_data = |q.mask;

    AST_CLEAR_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(clear && wr));  // R4
endmodule

// File: rtl/pwc_session.sv
module pwc_session
    import pwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic              cmd_a8,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              cs_rise,
    input  logic              cs_aligned,
    input  logic              wr_permit,
    input  logic              wip_in,
    input  logic              cycle_done,
    input  logic              has_data,
    output logic              wel,
    output logic [1:0]        bp,
    output logic              buf_clear,
    output logic              buf_wr,
    output logic [IDX_W-1:0]  idx_init,
    output logic              commit,
    output logic [PAGE_W-1:0] page_out
);
    typedef struct packed {
        sess_e             st;
        logic              wel;
        logic [1:0]        bp;
        logic [PAGE_W-1:0] page;
    } ses_t;

    ses_t q, d;

    always_comb begin
        d         = q;
        buf_clear = 1'b0;
        buf_wr    = 1'b0;
        commit    = 1'b0;
        case (q.st)
            SS_IDLE: begin
                if (cmd_valid) begin
                    d.st = SS_SKIP;
                    case (op_e'(cmd_code))
                        OP_WREN:  if (!wip_in) d.st = SS_EN_WAIT;
                        OP_WRDI:  if (!wip_in) d.wel = 1'b0;
                        OP_WRITE: if (q.wel && !wip_in && wr_permit) begin
                            d.st   = SS_ADDR;
                            d.page = {cmd_a8, {(PAGE_W-1){1'b0}}};
                        end
                        OP_WRSR:  if (q.wel && !wip_in) d.st = SS_SR;
                        default:  ;
                    endcase
                end
            end
            SS_EN_WAIT: begin
                if (byte_valid) d.st = SS_SKIP;
                else if (cs_rise) begin
                    if (cs_aligned) d.wel = 1'b1;
                    d.st = SS_IDLE;
                end
            end
            SS_ADDR: begin
                if (byte_valid) begin
                    d.page    = {q.page[PAGE_W-1], byte_data[DATA_W-1:IDX_W]};
                    buf_clear = 1'b1;
                    d.st      = SS_DATA;
                end else if (cs_rise) d.st = SS_IDLE;
            end
            SS_DATA: begin
                if (byte_valid) buf_wr = 1'b1;
                else if (cs_rise) begin
                    commit = cs_aligned && has_data && !page_locked(q.page, q.bp);
                    d.st   = SS_IDLE;
                end
            end
            SS_SR: begin
                if (byte_valid) begin
                    d.bp = byte_data[3:2];
                    d.st = SS_SKIP;
                end else if (cs_rise) d.st = SS_IDLE;
            end
            default: begin
                if (cs_rise) d.st = SS_IDLE;
            end
        endcase
        if (cycle_done) d.wel = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: SS_IDLE, wel: 1'b0, bp: 2'b00, page: '0};
        else        q <= d;
    end

    assign wel      = q.wel;
    assign bp       = q.bp;
    assign idx_init = byte_data[IDX_W-1:0];
    assign page_out = q.page;

    AST_COMMIT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (q.wel && !wip_in));  // R5
    AST_WEL_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip_in) |-> !q.wel);  // R7
    AST_BP_ONLY_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.bp) |-> $past(q.wel));  // R9
endmodule

// File: rtl/pwc_wr_engine.sv
module pwc_wr_engine
    import pwc_pkg::*;
#(
    parameter int WR_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PAGE_W-1:0] page_in,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_valid,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              wip,
    output logic              done,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);
    localparam int CW = $clog2(WR_CYCLES);
    localparam logic [CW-1:0] LAST_CNT  = CW'(WR_CYCLES - 1);
    localparam logic [CW-1:0] BURST_END = CW'(PAGE_BYTES);

    typedef struct packed {
        logic              wip;
        logic [CW-1:0]     cnt;
        logic [PAGE_W-1:0] page;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d    = q;
        done = q.wip && (q.cnt == LAST_CNT);
        if (start) begin
            d.wip  = 1'b1;
            d.cnt  = '0;
            d.page = page_in;
        end else if (q.wip) begin
            if (done) begin
                d.wip = 1'b0;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wip       = q.wip;
    assign rd_idx    = q.cnt[IDX_W-1:0];
    assign arr_we    = q.wip && (q.cnt < BURST_END) && rd_valid;
    assign arr_addr  = {q.page, rd_idx};
    assign arr_wdata = rd_data;

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !q.wip);  // R8
    AST_STROBE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> !done);  // R6
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
    import pwc_pkg::*;
#(
    parameter int WR_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic              cmd_a8,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              cs_rise,
    input  logic              cs_aligned,
    input  logic              wr_permit,
    output logic [7:0]        status,
    output logic              arr_we,
    output logic [8:0]        arr_addr,
    output logic [7:0]        arr_wdata
);
    logic              wel, wip, done, commit, buf_clear, buf_wr, has_data, rd_valid;
    logic [1:0]        bp;
    logic [IDX_W-1:0]  idx_init, rd_idx;
    logic [PAGE_W-1:0] page;
    logic [DATA_W-1:0] rd_data;

    pwc_session u_session (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_a8(cmd_a8),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .cs_rise(cs_rise), .cs_aligned(cs_aligned), .wr_permit(wr_permit),
        .wip_in(wip), .cycle_done(done), .has_data(has_data),
        .wel(wel), .bp(bp), .buf_clear(buf_clear), .buf_wr(buf_wr),
        .idx_init(idx_init), .commit(commit), .page_out(page)
    );

    pwc_page_buf u_buf (
        .clk(clk), .rst_n(rst_n),
        .clear(buf_clear), .idx_init(idx_init),
        .wr(buf_wr), .wdata(byte_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid),
        .has_data(has_data)
    );

    pwc_wr_engine #(.WR_CYCLES(WR_CYCLES)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .start(commit), .page_in(page),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_idx(rd_idx),
        .wip(wip), .done(done),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    assign status = {4'b0000, bp, wel, wip};

    initial begin
        assert (WR_CYCLES > PAGE_BYTES);  // R6
    end

    AST_WRITE_HOLDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> status[1]);  // R7
    AST_WIP_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(commit));  // R6
endmodule

// File: tb/page_write_ctrl_bench.sv
module page_write_ctrl_bench;
    localparam int WRC = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0, cmd_a8 = 1'b0, byte_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic [7:0] byte_data = 8'd0;
    logic       cs_rise = 1'b0, cs_aligned = 1'b0, wr_permit = 1'b1;
    logic [7:0] status, arr_wdata;
    logic       arr_we;
    logic [8:0] arr_addr;

    int checks = 0, errors = 0, we_count = 0;
    logic [7:0] shadow [512];
    logic [7:0] expm   [512];

    always #5 clk = ~clk;

    page_write_ctrl #(.WR_CYCLES(WRC)) u_page_write_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_a8(cmd_a8), .byte_valid(byte_valid), .byte_data(byte_data),
        .cs_rise(cs_rise), .cs_aligned(cs_aligned), .wr_permit(wr_permit),
        .status(status), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    always @(posedge clk) if (arr_we) begin
        shadow[arr_addr] <= arr_wdata;
        we_count <= we_count + 1;
    end

    typedef struct packed {
        logic       wen;
        logic       wp;
        logic       a8;
        logic [7:0] addr;
        logic [4:0] n;
        logic       al;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b1, 1'b0, 8'h00, 5'd1,  1'b1},  // single byte
        '{1'b1, 1'b1, 1'b0, 8'h13, 5'd16, 1'b1},  // full page from index 3
        '{1'b1, 1'b1, 1'b1, 8'h2A, 5'd20, 1'b1},  // past page end, overwrite
        '{1'b1, 1'b1, 1'b0, 8'h40, 5'd3,  1'b0},  // misaligned rise
        '{1'b0, 1'b1, 1'b0, 8'h50, 5'd2,  1'b1},  // latch not set
        '{1'b1, 1'b0, 1'b0, 8'h60, 5'd2,  1'b1},  // write-protect low
        '{1'b1, 1'b1, 1'b0, 8'h70, 5'd0,  1'b1},  // no data bytes
        '{1'b1, 1'b1, 1'b1, 8'hFF, 5'd2,  1'b1}   // index 15 wraps to 0
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] c, input logic a8);
        @(negedge clk); cmd_valid = 1'b1; cmd_code = c; cmd_a8 = a8;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic sendb(input logic [7:0] b);
        @(negedge clk); byte_valid = 1'b1; byte_data = b;
        @(negedge clk); byte_valid = 1'b0;
    endtask

    task automatic csr(input logic al);
        @(negedge clk); cs_rise = 1'b1; cs_aligned = al;
        @(negedge clk); cs_rise = 1'b0; cs_aligned = 1'b0;
    endtask

    task automatic wip_len(output int len);
        len = 0;
        while (status[0] && len < 1000) begin
            len++;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic wren(); cmd(3'd1, 1'b0); csr(1'b1); endtask

    function automatic logic [7:0] dat(input int v, input int i);
        return 8'(v * 37 + i * 11 + 3);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int len, base, c0;
        logic ok;
        for (int a = 0; a < 512; a++) begin shadow[a] = 8'h00; expm[a] = 8'h00; end
        repeat (3) @(negedge clk);
        chk(status == 8'h00, "R11 reset status", status, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(status == 8'h00 && we_count == 0, "R11 idle after reset", status, 0);

        for (int v = 0; v < NV; v++) begin
            logic cm;
            int nb;
            cmd(3'd2, 1'b0); csr(1'b1);
            if (TBL[v].wen) wren();
            wr_permit = TBL[v].wp;
            c0 = we_count;
            cmd(3'd3, TBL[v].a8);
            sendb(TBL[v].addr);
            for (int i = 0; i < int'(TBL[v].n); i++) sendb(dat(v, i));
            csr(TBL[v].al);
            wip_len(len);
            wr_permit = 1'b1;
            cm = TBL[v].wen && TBL[v].wp && TBL[v].al && (TBL[v].n != 0);
            base = {TBL[v].a8, TBL[v].addr[7:4], 4'h0};
            if (cm)
                for (int i = 0; i < int'(TBL[v].n); i++)
                    expm[base + ((int'(TBL[v].addr[3:0]) + i) % 16)] = dat(v, i);
            nb = cm ? ((TBL[v].n > 16) ? 16 : int'(TBL[v].n)) : 0;
            chk(len == (cm ? WRC : 0), $sformatf("R6 R5 vec%0d wip length", v), len, cm ? WRC : 0);
            chk(we_count - c0 == nb, $sformatf("R6 R3 vec%0d array writes", v), we_count - c0, nb);
            ok = 1'b1;
            for (int i = 0; i < 16; i++) if (shadow[base + i] !== expm[base + i]) ok = 1'b0;
            chk(ok, $sformatf("R4 R5 vec%0d page contents", v), shadow[base], expm[base]);
            chk(status[1] == (TBL[v].wen && !cm), $sformatf("R7 R5 vec%0d latch after", v),
                status[1], TBL[v].wen && !cm);
        end

        // R1 latch rules
        cmd(3'd2, 1'b0); csr(1'b1);
        cmd(3'd1, 1'b0); csr(1'b0);
        chk(status[1] == 1'b0, "R1 misaligned enable", status[1], 0);
        cmd(3'd1, 1'b0); sendb(8'h00); csr(1'b1);
        chk(status[1] == 1'b0, "R1 enable with extra byte", status[1], 0);
        wren();
        chk(status == 8'h02, "R1 enable sets latch", status, 8'h02);
        cmd(3'd2, 1'b0);
        chk(status[1] == 1'b0, "R2 disable clears at once", status[1], 0);
        csr(1'b1);

        // R8 commands during a write cycle
        wren();
        c0 = we_count;
        cmd(3'd3, 1'b0); sendb(8'h80); sendb(8'hC3); csr(1'b1);
        chk(status == 8'h03, "R8 status during cycle", status, 8'h03);
        cmd(3'd2, 1'b0); csr(1'b1);
        chk(status[1] == 1'b1, "R2 disable ignored in cycle", status[1], 1);
        cmd(3'd4, 1'b0); sendb(8'h0C); csr(1'b1);
        chk(status[3:2] == 2'b00, "R8 status write ignored in cycle", status[3:2], 0);
        cmd(3'd3, 1'b0); sendb(8'h90); sendb(8'h77); csr(1'b1);
        cmd(3'd1, 1'b0); csr(1'b1);
        wip_len(len);
        chk(we_count - c0 == 1 && shadow[9'h080] == 8'hC3 && shadow[9'h090] == 8'h00,
            "R8 no write started in cycle", we_count - c0, 1);
        chk(status == 8'h00, "R7 latch cleared after cycle", status, 0);

        // R9 status write
        cmd(3'd4, 1'b0); sendb(8'h0C); csr(1'b1);
        chk(status[3:2] == 2'b00, "R9 status write without latch", status[3:2], 0);
        wren(); cmd(3'd4, 1'b0); sendb(8'h08); csr(1'b1);
        chk(status == 8'h0A, "R9 status write with latch", status, 8'h0A);

        // R10 protection, BP=10
        c0 = we_count;
        cmd(3'd3, 1'b1); sendb(8'h00); sendb(8'h5E); csr(1'b1);
        wip_len(len);
        chk(len == 0 && we_count == c0, "R10 upper half blocked", we_count - c0, 0);
        cmd(3'd3, 1'b0); sendb(8'hF0); sendb(8'h6D); csr(1'b1);
        wip_len(len);
        chk(we_count - c0 == 1 && shadow[9'h0F0] == 8'h6D, "R10 lower half allowed",
            shadow[9'h0F0], 8'h6D);
        // BP=01
        wren(); cmd(3'd4, 1'b0); sendb(8'h04); csr(1'b1);
        c0 = we_count;
        cmd(3'd3, 1'b1); sendb(8'hC0); sendb(8'h4B); csr(1'b1);
        wip_len(len);
        chk(we_count == c0, "R10 upper quarter blocked", we_count - c0, 0);
        cmd(3'd3, 1'b1); sendb(8'h70); sendb(8'h39); csr(1'b1);
        wip_len(len);
        chk(we_count - c0 == 1 && shadow[9'h170] == 8'h39, "R10 below quarter allowed",
            shadow[9'h170], 8'h39);
        chk(status[7:4] == 4'h0, "R11 upper status bits zero", status[7:4], 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule